// File: doc/BRIEF.md
# Carry-Predicated Dual-Width ALU Stage

This block is the execute stage of a small controller whose data path is 16 bits wide but whose registers and addresses are 24 bits wide. On each accepted request it performs one of ten operations: add, add with carry, subtract, subtract with borrow, compare, compare with borrow, AND, OR, XOR and one's complement. It returns the destination value, a destination write strobe, the four condition flags and a flag write strobe, all registered one clock after the request.

Add, subtract and compare can run at 16 or 24 bits. All other operations are 16 bits wide, and every 16-bit result reaches the destination zero-extended. The second operand is either a register value or a 7-bit immediate. Whether the immediate is zero-extended or sign-extended depends on the operation. A register-to-register request can be made conditional on the incoming carry flag. When the condition fails, the request writes nothing.

A two-state controller tracks whether the output registers hold a fresh result. `ST_IDLE` means no result is pending. `ST_HOLD` means the outputs carry the result of the request accepted on the previous edge. The transition IDLE→HOLD is taken on a request. HOLD→HOLD is taken on a back-to-back request. HOLD→IDLE is taken when no request arrives. IDLE→IDLE is taken otherwise.

Top module: `cedw_alu`

## Requirements
- R1: A request with `in_valid`=1 is answered on the next clock edge with `out_valid`=1. A cycle without a request gives `out_valid`, `result_we` and `flags_we` all 0 on the next edge, and all three are 0 after reset.
- R2: Opcode 0 (add) and opcode 2 (subtract) work at 24 bits when `wide_sel`=1 and at 16 bits when `wide_sel`=0.
- R3: Opcode 1 adds operand B plus the incoming C flag. Opcode 3 subtracts operand B and the incoming C, which is taken as a borrow. Both are always 16-bit and ignore `wide_sel`.
- R4: Opcode 4 (compare, 16 or 24 bits by `wide_sel`) and opcode 5 (compare with borrow, 16 bits, subtracts C as well) update the flags with `flags_we`=1 but keep `result_we`=0.
- R5: With `imm_sel`=0, `pred_sel` = 1 executes only when C=1 and 2 executes only when C=0, while 0 and 3 always execute. With `imm_sel`=1 the predicate is ignored. A failed predicate gives `result_we`=0, `flags_we`=0, `result`=`opnd_a` and `flags_out`=`flags_in`.
- R6: The 7-bit immediate is zero-extended for opcodes 0–3 and for a 24-bit compare. It is sign-extended for a 16-bit compare and for opcodes 5–9.
- R7: Every 16-bit result is written with bits 23:16 equal to zero.
- R8: Opcodes 6, 7, 8 and 9 give the AND, OR and XOR of A and B, and the one's complement of B, all at 16 bits. They clear C and V.
- R9: The flags are packed as bit 3 N, bit 2 Z, bit 1 V and bit 0 C. N is the top bit of the active width and Z marks a zero result. C is the carry out for additions and the borrow for subtractions. V is signed overflow at the active width.
- R10: Opcodes 10–15 execute nothing. They give `result_we`=0, `flags_we`=0, `result`=`opnd_a` and `flags_out`=`flags_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| op_code | input | 4 | Operation select (R2–R4, R8, R10) |
| wide_sel | input | 1 | 24-bit width for add, subtract and compare |
| imm_sel | input | 1 | Operand B taken from the immediate |
| pred_sel | input | 2 | Carry predicate for register forms |
| opnd_a | input | 24 | First operand and old destination value |
| opnd_b | input | 24 | Second register operand |
| imm_field | input | 7 | Immediate field |
| flags_in | input | 4 | Current flags {N,Z,V,C} |
| out_valid | output | 1 | Result registers hold a fresh result |
| result | output | 24 | Destination value |
| result_we | output | 1 | Destination write strobe |
| flags_out | output | 4 | New flags {N,Z,V,C} |
| flags_we | output | 1 | Flag write strobe |

## Verification
The output registers and the controller state are loaded on the same edge, so any wrong internal state shows at the ports one cycle after the request that caused it. Examples are a stale state bit, a strobe left high or a wrong width choice. A wrong width or extension choice shows as nonzero upper bits, or as an N/C flag taken from the wrong bit. A predicate error shows as a write strobe that should be low. Each request is therefore compared in full in the cycle right after it, and a cycle without a request confirms that the strobes have dropped.

// File: rtl/cedw_alu_pkg.sv
package cedw_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_CMP = 4'd4,
        OP_CMC = 4'd5,
        OP_AND = 4'd6,
        OP_OR  = 4'd7,
        OP_XOR = 4'd8,
        OP_NOT = 4'd9
    } alu_op_e;

    typedef enum logic [1:0] {
        PR_ALWAYS = 2'd0,
        PR_IF_C   = 2'd1,
        PR_IF_NC  = 2'd2,
        PR_SPARE  = 2'd3
    } pred_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } stage_st_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

endpackage

// File: rtl/cedw_opsel.sv
module cedw_opsel
    import cedw_alu_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int IMM_W  = 7
) (
    input  logic [3:0]        op,
    input  logic              wide,
    input  logic              use_imm,
    input  logic [1:0]        pred,
    input  logic              c_flag,
    input  logic [DATA_W-1:0] opb,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] src_b,
    output logic              pred_ok,
    output logic              op_known
);

    localparam int EXT_W = DATA_W - IMM_W;

    logic signed_imm;
    logic [DATA_W-1:0] imm_ext;

    always_comb begin
        signed_imm = 1'b0;
        case (op)
            OP_CMP:                         signed_imm = !wide;
            OP_CMC, OP_AND, OP_OR,
            OP_XOR, OP_NOT:                 signed_imm = 1'b1;
            default:                        signed_imm = 1'b0;
        endcase
    end

    always_comb begin
        if (signed_imm)
            imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
        else
            imm_ext = {{EXT_W{1'b0}}, imm};
        src_b = use_imm ? imm_ext : opb;
    end

    always_comb begin
        if (use_imm) begin
            pred_ok = 1'b1;
        end else begin
            unique case (pred_e'(pred))
                PR_ALWAYS: pred_ok = 1'b1;
                PR_IF_C:   pred_ok = c_flag;
                PR_IF_NC:  pred_ok = !c_flag;
                PR_SPARE:  pred_ok = 1'b1;
            endcase
        end
    end

    assign op_known = (op <= OP_NOT);

endmodule

// File: rtl/cedw_addsub.sv
module cedw_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         with_flag,
    input  logic         c_flag,
    output logic [W-1:0] sum,
    output logic         c_out,
    output logic         v_out
);

    logic [W-1:0] b_eff;
    logic         cin;
    logic         carry;

    always_comb begin
        b_eff = sub ? ~b : b;
        if (sub)
            cin = with_flag ? ~c_flag : 1'b1;
        else
            cin = with_flag ? c_flag : 1'b0;
        {carry, sum} = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
        c_out = sub ? ~carry : carry;
        v_out = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end

endmodule

// File: rtl/cedw_logic.sv
module cedw_logic
    import cedw_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] r
);

    always_comb begin
        case (op)
            OP_AND:  r = a & b;
            OP_OR:   r = a | b;
            OP_XOR:  r = a ^ b;
            OP_NOT:  r = ~b;
            default: r = '0;
        endcase
    end

endmodule

// File: rtl/cedw_alu.sv
module cedw_alu
    import cedw_alu_pkg::*;
#(
    parameter int DATA_W   = 24,
    parameter int NARROW_W = 16,
    parameter int IMM_W    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op_code,
    input  logic              wide_sel,
    input  logic              imm_sel,
    input  logic [1:0]        pred_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [IMM_W-1:0]  imm_field,
    input  logic [3:0]        flags_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              result_we,
    output logic [3:0]        flags_out,
    output logic              flags_we
);

    localparam int PAD_W = DATA_W - NARROW_W;

    flags_t            cur_flags;
    logic [DATA_W-1:0] src_b;
    logic              pred_ok;
    logic              op_known;

    logic              is_sub;
    logic              with_flag;
    logic              is_logic;
    logic              go_wide;
    logic              writes_dest;
    logic              execute;

    logic [NARROW_W-1:0] sum_n;
    logic                c_n;
    logic                v_n;
    logic [DATA_W-1:0]   sum_w;
    logic                c_w;
    logic                v_w;
    logic [NARROW_W-1:0] lg_r;

    logic [DATA_W-1:0] new_res;
    flags_t            new_flags;

    stage_st_e         st_q;
    stage_st_e         st_d;
    logic [DATA_W-1:0] res_q;
    logic              res_we_q;
    flags_t            flags_q;
    logic              flags_we_q;

    assign cur_flags = flags_t'(flags_in);

    cedw_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
        .op       (op_code),
        .wide     (wide_sel),
        .use_imm  (imm_sel),
        .pred     (pred_sel),
        .c_flag   (cur_flags.c),
        .opb      (opnd_b),
        .imm      (imm_field),
        .src_b    (src_b),
        .pred_ok  (pred_ok),
        .op_known (op_known)
    );

    always_comb begin
        is_sub      = (op_code == OP_SUB) || (op_code == OP_SBC) ||
                      (op_code == OP_CMP) || (op_code == OP_CMC);
        with_flag   = (op_code == OP_ADC) || (op_code == OP_SBC) ||
                      (op_code == OP_CMC);
        is_logic    = (op_code >= OP_AND) && (op_code <= OP_NOT);
        go_wide     = wide_sel && ((op_code == OP_ADD) || (op_code == OP_SUB) ||
                                   (op_code == OP_CMP));
        writes_dest = op_known && (op_code != OP_CMP) && (op_code != OP_CMC);
        execute     = op_known && pred_ok;
    end

    cedw_addsub #(.W(NARROW_W)) u_add_narrow (
        .a         (opnd_a[NARROW_W-1:0]),
        .b         (src_b[NARROW_W-1:0]),
        .sub       (is_sub),
        .with_flag (with_flag),
        .c_flag    (cur_flags.c),
        .sum       (sum_n),
        .c_out     (c_n),
        .v_out     (v_n)
    );

    cedw_addsub #(.W(DATA_W)) u_add_wide (
        .a         (opnd_a),
        .b         (src_b),
        .sub       (is_sub),
        .with_flag (with_flag),
        .c_flag    (cur_flags.c),
        .sum       (sum_w),
        .c_out     (c_w),
        .v_out     (v_w)
    );

    cedw_logic #(.W(NARROW_W)) u_logic (
        .op (op_code),
        .a  (opnd_a[NARROW_W-1:0]),
        .b  (src_b[NARROW_W-1:0]),
        .r  (lg_r)
    );

    always_comb begin
        if (is_logic) begin
            new_res     = {{PAD_W{1'b0}}, lg_r};
            new_flags.n = lg_r[NARROW_W-1];
            new_flags.z = (lg_r == '0);
            new_flags.v = 1'b0;
            new_flags.c = 1'b0;
        end else if (go_wide) begin
            new_res     = sum_w;
            new_flags.n = sum_w[DATA_W-1];
            new_flags.z = (sum_w == '0);
            new_flags.v = v_w;
            new_flags.c = c_w;
        end else begin
            new_res     = {{PAD_W{1'b0}}, sum_n};
            new_flags.n = sum_n[NARROW_W-1];
            new_flags.z = (sum_n == '0);
            new_flags.v = v_n;
            new_flags.c = c_n;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: st_d = in_valid ? ST_HOLD : ST_IDLE;
            ST_HOLD: st_d = in_valid ? ST_HOLD : ST_IDLE;
        endcase
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q      <= '0;
            res_we_q   <= 1'b0;
            flags_q    <= '0;
            flags_we_q <= 1'b0;
        end else if (in_valid) begin
            res_q      <= (execute && writes_dest) ? new_res : opnd_a;
            res_we_q   <= execute && writes_dest;
            flags_q    <= execute ? new_flags : cur_flags;
            flags_we_q <= execute;
        end else begin
            res_we_q   <= 1'b0;
            flags_we_q <= 1'b0;
        end
    end

    assign out_valid = (st_q == ST_HOLD);
    assign result    = res_q;
    assign result_we = res_we_q;
    assign flags_out = flags_q;
    assign flags_we  = flags_we_q;

endmodule

// File: rtl/cedw_alu_chk.sv
module cedw_alu_chk #(
    parameter int DATA_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [3:0]        op_code,
    input logic              wide_sel,
    input logic              imm_sel,
    input logic [1:0]        pred_sel,
    input logic [DATA_W-1:0] opnd_a,
    input logic [3:0]        flags_in,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              result_we,
    input logic [3:0]        flags_out,
    input logic              flags_we
);

    logic pred_fail;
    logic narrow_op;
    logic logic_op;
    assign pred_fail = !imm_sel && (((pred_sel == 2'd1) && !flags_in[0]) ||
                                    ((pred_sel == 2'd2) &&  flags_in[0]));
    assign narrow_op = !(wide_sel && ((op_code == 4'd0) || (op_code == 4'd2) ||
                                      (op_code == 4'd4)));
    assign logic_op  = (op_code >= 4'd6) && (op_code <= 4'd9);

    p_valid_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !result_we && !flags_we));

    p_cmp_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ((op_code == 4'd4) || (op_code == 4'd5)) && !pred_fail)
        |=> (!result_we && flags_we));

    p_pred_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pred_fail) |=>
        (!result_we && !flags_we && result == $past(opnd_a) && flags_out == $past(flags_in)));

    p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && narrow_op) |=> (!result_we || result[DATA_W-1:16] == '0));

    p_logic_cv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && logic_op && !pred_fail) |=> (flags_we && !flags_out[1] && !flags_out[0]));

    p_unknown_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code > 4'd9) |=> (!result_we && !flags_we));

endmodule

bind cedw_alu cedw_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_code   (op_code),
    .wide_sel  (wide_sel),
    .imm_sel   (imm_sel),
    .pred_sel  (pred_sel),
    .opnd_a    (opnd_a),
    .flags_in  (flags_in),
    .out_valid (out_valid),
    .result    (result),
    .result_we (result_we),
    .flags_out (flags_out),
    .flags_we  (flags_we)
);

// File: tb/cedw_alu_tb.sv
`timescale 1ns/1ps
module cedw_alu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic        wide_sel = 1'b0;
    logic        imm_sel = 1'b0;
    logic [1:0]  pred_sel = '0;
    logic [23:0] opnd_a = '0;
    logic [23:0] opnd_b = '0;
    logic [6:0]  imm_field = '0;
    logic [3:0]  flags_in = '0;
    logic        out_valid;
    logic [23:0] result;
    logic        result_we;
    logic [3:0]  flags_out;
    logic        flags_we;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cedw_alu u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .wide_sel(wide_sel), .imm_sel(imm_sel), .pred_sel(pred_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .imm_field(imm_field),
        .flags_in(flags_in), .out_valid(out_valid), .result(result),
        .result_we(result_we), .flags_out(flags_out), .flags_we(flags_we)
    );

    // Expected {out_valid, result, result_we, flags_we, flags} per requirements
    function automatic logic [30:0] model(input logic [3:0] op, input logic wd,
                                          input logic ui, input logic [1:0] pr,
                                          input logic [23:0] a, input logic [23:0] b,
                                          input logic [6:0] im, input logic [3:0] fl);
        int w;
        longint mask, av, bv, tot, sa, sb, sr, lim, r, cin;
        logic [23:0] bsrc;
        logic sgn, ex, wr, c, v, n, z;
        w = (wd && (op == 0 || op == 2 || op == 4)) ? 24 : 16;
        mask = (longint'(1) << w) - 1;
        sgn = (op == 4 && !wd) || (op >= 5 && op <= 9);
        bsrc = ui ? (sgn && im[6] ? {17'h1FFFF, im} : {17'h0, im}) : b;
        ex = (op <= 9) && (ui || pr == 0 || pr == 3 || (pr == 1 && fl[0]) || (pr == 2 && !fl[0]));
        wr = ex && op != 4 && op != 5;
        if (!ex) return {1'b1, a, 1'b0, 1'b0, fl};
        av = longint'(a) & mask;
        bv = longint'(bsrc) & mask;
        sa = ((av >> (w-1)) & 1) != 0 ? av - (mask + 1) : av;
        sb = ((bv >> (w-1)) & 1) != 0 ? bv - (mask + 1) : bv;
        lim = longint'(1) << (w-1);
        c = 0; v = 0;
        if (op == 0 || op == 1) begin
            cin = (op == 1) ? longint'(fl[0]) : 0;
            tot = av + bv + cin;
            c = ((tot >> w) & 1) != 0;
            sr = sa + sb + cin;
            v = (sr >= lim) || (sr < -lim);
            r = tot & mask;
        end else if (op >= 2 && op <= 5) begin
            cin = (op == 3 || op == 5) ? longint'(fl[0]) : 0;
            tot = av - bv - cin;
            c = tot < 0;
            sr = sa - sb - cin;
            v = (sr >= lim) || (sr < -lim);
            r = tot & mask;
        end else begin
            case (op)
                6: r = av & bv;
                7: r = av | bv;
                8: r = av ^ bv;
                default: r = (~bv) & mask;
            endcase
        end
        n = ((r >> (w-1)) & 1) != 0;
        z = (r == 0);
        return {1'b1, wr ? r[23:0] : a, wr, 1'b1, n, z, v, c};
    endfunction

    function automatic string tag(input logic [3:0] op, input logic ui, input logic [1:0] pr);
        if (op > 9) return "R10";
        if (!ui && (pr == 1 || pr == 2)) return "R5";
        if (op == 4 || op == 5) return "R4";
        if (op == 1 || op == 3) return "R3";
        if (op >= 6) return "R8";
        return "R2";
    endfunction

    task automatic check(input string req, input logic [30:0] act, input logic [30:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] op, input logic wd, input logic ui,
                         input logic [1:0] pr, input logic [23:0] a, input logic [23:0] b,
                         input logic [6:0] im, input logic [3:0] fl, input string req);
        logic [30:0] exp;
        @(negedge clk);
        in_valid = 1; op_code = op; wide_sel = wd; imm_sel = ui; pred_sel = pr;
        opnd_a = a; opnd_b = b; imm_field = im; flags_in = fl;
        exp = model(op, wd, ui, pr, a, b, im, fl);
        @(negedge clk);
        in_valid = 0;
        check(req, {out_valid, result, result_we, flags_we, flags_out}, exp);
    endtask

    task automatic expect_lit(input string req, input logic [23:0] r, input logic [3:0] f);
        check(req, {out_valid, result, result_we, flags_we, flags_out}, {1'b1, r, 1'b1, 1'b1, f});
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected<100000", cyc);
                $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {out_valid, result, result_we, flags_we, flags_out}, 31'd0);
        rst_n = 1;

        // R2 / R9: 16-bit signed overflow 0x7FFF + 1
        issue(0, 0, 0, 0, 24'h007FFF, 24'h000001, 0, 4'b0000, "R9");
        expect_lit("R9", 24'h008000, 4'b1010);
        // R2: 24-bit wrap
        issue(0, 1, 0, 0, 24'hFFFFFF, 24'h000001, 0, 4'b0000, "R2");
        expect_lit("R2", 24'h000000, 4'b0101);
        // R7: 16-bit add drops upper bits
        issue(0, 0, 0, 0, 24'hFFFFFF, 24'h000001, 0, 4'b0000, "R7");
        expect_lit("R7", 24'h000000, 4'b0101);
        // R3: add with carry, subtract with borrow
        issue(1, 1, 0, 0, 24'h000010, 24'h000001, 0, 4'b0001, "R3");
        expect_lit("R3", 24'h000012, 4'b0000);
        issue(3, 0, 0, 0, 24'h000000, 24'h000000, 0, 4'b0001, "R3");
        expect_lit("R3", 24'h00FFFF, 4'b1001);
        // R4 / R6: 16-bit compare with sign-extended -1
        issue(4, 0, 1, 0, 24'h00FFFF, 0, 7'h7F, 4'b0000, "R6");
        // R6: 24-bit compare with zero-extended 0x7F
        issue(4, 1, 1, 0, 24'h00007F, 0, 7'h7F, 4'b0000, "R6");
        // R6 / R8: AND with sign-extended immediate
        issue(6, 0, 1, 0, 24'h001234, 0, 7'h40, 4'b0000, "R8");
        expect_lit("R8", 24'h001200, 4'b0000);
        // R8: NOT of operand B
        issue(9, 0, 0, 0, 24'h000000, 24'h00FF00, 0, 4'b0011, "R8");
        expect_lit("R8", 24'h0000FF, 4'b0000);
        // R5: predicate forms
        issue(0, 0, 0, 1, 24'h123456, 24'h000001, 0, 4'b0000, "R5");
        issue(0, 0, 0, 2, 24'h123456, 24'h000001, 0, 4'b0000, "R5");
        issue(2, 0, 0, 2, 24'h123456, 24'h000001, 0, 4'b0001, "R5");
        issue(2, 0, 1, 1, 24'h000005, 0, 7'h03, 4'b0000, "R5");
        // R10: unassigned opcode
        issue(12, 0, 0, 0, 24'hABCDEF, 24'h111111, 0, 4'b1010, "R10");
        // R1: strobes drop on an idle cycle
        @(negedge clk);
        check("R1", {out_valid, result_we, flags_we}, 3'b000);

        for (int i = 0; i < 500; i++) begin
            logic [3:0] op;
            logic ui;
            logic [1:0] pr;
            op = ($urandom % 8 == 0) ? 4'($urandom % 16) : 4'($urandom % 10);
            ui = 1'($urandom);
            pr = 2'($urandom);
            issue(op, 1'($urandom), ui, pr, 24'($urandom), 24'($urandom),
                  7'($urandom), 4'($urandom), tag(op, ui, pr));
            if ($urandom % 10 == 0) begin
                @(negedge clk);
                check("R1", {out_valid, result_we, flags_we}, 3'b000);
            end
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule